// File: doc/BRIEF.md
# Idle Interval Timer

This block keeps a free-running counter that advances once per instruction-cycle enable and uses it to time a low-power idle state. In that state program execution stops while the oscillator keeps running. A small window-select register picks one of several counter taps. Each time the chosen tap drops from one to zero, a window event occurs. The event sets a sticky pending flag, raises an interrupt request if the interrupt enable is high, and ends the idle state if the core is idle.

Software cannot read, load, start or stop the counter. An idle period that is not aligned to the counter therefore lasts anywhere from one cycle up to the full window. Software aligns to the counter by waiting for the pending flag before it requests idle. Writing a new window code compares the old tap with the newly chosen one, so the write itself can produce a spurious event. The idle request comes from the core's port-write decode as a one-cycle strobe. The wakeup input carries an external wake request into the block.

Top module: `idle_tmr`

## Requirements
- R1: After reset, pending, irq and idleActive are 0, and the window code is 0 (the shortest window).
- R2: The counter advances by one only in clock cycles with tickEn high, whether or not the block is idle. Window code k (0 to NUM_WIN-1) gives one window event every 2^(TAP_BASE+k) ticks. The event fires when counter bit TAP_BASE-1+k falls from 1 to 0.
- R3: Window codes above NUM_WIN-1 select the longest window, 2^(TAP_BASE+NUM_WIN-1) ticks.
- R4: A window event sets pending at the next clock edge. Pending then stays set until a cycle with pendClr high and no event. An event in the same cycle as pendClr leaves pending set.
- R5: irq is high exactly when pending is high and irqEnable is high.
- R6: idleReq high sets idleActive at the next edge. This holds even if wakeup or a window event occurs in the same cycle.
- R7: While idleActive, a window event clears idleActive at the same edge that sets pending.
- R8: While idleActive, wakeup high clears idleActive at the next edge.
- R9: The event detector compares the selected tap with the tap value held from the previous cycle. Writing a new code while the old tap reads 1 and the new tap reads 0 produces an event, even with the counter stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Instruction-cycle enable; the counter steps in cycles where it is high |
| selWrEn | input | 1 | Write strobe for the window-select register |
| selWrData | input | SEL_W | Window code to write |
| irqEnable | input | 1 | Interrupt enable level |
| pendClr | input | 1 | Pending-flag clear strobe |
| idleReq | input | 1 | Idle entry request strobe |
| wakeup | input | 1 | External wakeup request |
| pending | output | 1 | Sticky window-event flag |
| irq | output | 1 | Interrupt request |
| idleActive | output | 1 | High while the block holds the core idle |

## Verification
The bench builds the block with TAP_BASE=3, NUM_WIN=5 and SEL_W=3. This shrinks the windows to 8 to 128 ticks and the counter to 7 bits. Every window code, the clamped codes, full counter wraps and idle exits by event therefore fit into a few thousand cycles. The bench also divides the tick rate and stops it outright. This shows that window lengths scale with ticks and not with clocks. With the counter stopped, a sweep of window writes can produce only the spurious events that the old and new taps cause.

// File: rtl/idle_tmr_pkg.sv
package idle_tmr_pkg;

  // Strobes from the control unit to the timing datapath
  typedef struct packed {
    logic countStep;  // advance the free-running counter
    logic selLoad;    // load a new window code
  } dpStrobe_t;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_IDLE = 1'b1
  } idleState_t;

endpackage

// File: rtl/idle_tmr_cnt.sv
// Free-running up counter; it steps only when enabled (R2)
module idle_tmr_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             step,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (step) begin
      count <= count + CNT_W'(1);
    end
  end

endmodule

// File: rtl/idle_tmr_dp.sv
// Timing datapath: counter, window register, tap selection, fall detector
module idle_tmr_dp
  import idle_tmr_pkg::*;
#(
  parameter int TAP_BASE = 12,
  parameter int NUM_WIN  = 5,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [SEL_W-1:0] selData,
  output logic             winEvent
);

  localparam int CNT_W = TAP_BASE + NUM_WIN - 1;
  localparam int IDX_W = $clog2(NUM_WIN);
  localparam int MAX_IDX = NUM_WIN - 1;

  logic [CNT_W-1:0]   count;
  logic [SEL_W-1:0]   winSel;
  logic [NUM_WIN-1:0] taps;
  logic [IDX_W-1:0]   tapIdx;
  logic               curTap;
  logic               prevTap;

  idle_tmr_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rstN  (rstN),
    .step  (strobe.countStep),
    .count (count)
  );

  // Window register; reset selects the shortest window (R1)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winSel <= '0;
    end else if (strobe.selLoad) begin
      winSel <= selData;
    end
  end

  // One tap per window; tap g halves its rate with each step in g
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_tap
    assign taps[g] = count[TAP_BASE-1+g];
  end

  // Codes past the last window clamp to the longest one (R3)
  always_comb begin
    if (winSel >= SEL_W'(MAX_IDX)) begin
      tapIdx = IDX_W'(MAX_IDX);
    end else begin
      tapIdx = IDX_W'(winSel);
    end
  end

  always_comb begin
    curTap = 1'b0;
    for (int g = 0; g < NUM_WIN; g++) begin
      if (tapIdx == IDX_W'(g)) begin
        curTap = taps[g];
      end
    end
  end

  // Tap held from the previous cycle, whichever window was selected (R9)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevTap <= 1'b0;
    end else begin
      prevTap <= curTap;
    end
  end

  // Falling edge of the selected tap marks a window boundary (R2)
  assign winEvent = prevTap & ~curTap;

endmodule

// File: rtl/idle_tmr_ctrl.sv
// Control: pending flag, interrupt gating, idle state
module idle_tmr_ctrl
  import idle_tmr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tickEn,
  input  logic      selWrEn,
  input  logic      pendClr,
  input  logic      idleReq,
  input  logic      wakeup,
  input  logic      irqEnable,
  input  logic      winEvent,
  output dpStrobe_t strobe,
  output logic      pending,
  output logic      irq,
  output logic      idleActive
);

  idleState_t state, stateNext;
  logic       pendNext;

  always_comb begin
    strobe.countStep = tickEn;
    strobe.selLoad   = selWrEn;
  end

  // An event outranks a simultaneous clear (R4)
  always_comb begin
    pendNext = winEvent | (pending & ~pendClr);
  end

  // Entry outranks a simultaneous exit (R6); exit on event (R7) or wakeup (R8)
  always_comb begin
    stateNext = state;
    if (idleReq) begin
      stateNext = ST_IDLE;
    end else if (state == ST_IDLE && (winEvent || wakeup)) begin
      stateNext = ST_RUN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_RUN;
      pending <= 1'b0;
    end else begin
      state   <= stateNext;
      pending <= pendNext;
    end
  end

  assign idleActive = (state == ST_IDLE);
  assign irq        = pending & irqEnable;  // R5

endmodule

// File: rtl/idle_tmr.sv
// Top: control and datapath joined by the strobe struct
module idle_tmr
  import idle_tmr_pkg::*;
#(
  parameter int TAP_BASE = 12,
  parameter int NUM_WIN  = 5,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             selWrEn,
  input  logic [SEL_W-1:0] selWrData,
  input  logic             irqEnable,
  input  logic             pendClr,
  input  logic             idleReq,
  input  logic             wakeup,
  output logic             pending,
  output logic             irq,
  output logic             idleActive
);

  dpStrobe_t strobe;
  logic      winEvent;

  idle_tmr_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .selWrEn    (selWrEn),
    .pendClr    (pendClr),
    .idleReq    (idleReq),
    .wakeup     (wakeup),
    .irqEnable  (irqEnable),
    .winEvent   (winEvent),
    .strobe     (strobe),
    .pending    (pending),
    .irq        (irq),
    .idleActive (idleActive)
  );

  idle_tmr_dp #(
    .TAP_BASE (TAP_BASE),
    .NUM_WIN  (NUM_WIN),
    .SEL_W    (SEL_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .selData  (selWrData),
    .winEvent (winEvent)
  );

endmodule

// File: rtl/idle_tmr_chk.sv
module idle_tmr_chk (
  input logic clk,
  input logic rstN,
  input logic pendClr,
  input logic idleReq,
  input logic wakeup,
  input logic irqEnable,
  input logic winEvent,
  input logic pending,
  input logic irq,
  input logic idleActive
);

  a_r4_event_sets: assert property (@(posedge clk) disable iff (!rstN)
    winEvent |=> pending);

  a_r4_pend_hold: assert property (@(posedge clk) disable iff (!rstN)
    pending && !pendClr |=> pending);

  a_r4_clear: assert property (@(posedge clk) disable iff (!rstN)
    pendClr && !winEvent |=> !pending);

  a_r5_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnable |-> !irq);

  a_r5_irq_needs_pend: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> pending);

  a_r6_enter: assert property (@(posedge clk) disable iff (!rstN)
    idleReq |=> idleActive);

  a_r7_event_exit: assert property (@(posedge clk) disable iff (!rstN)
    idleActive && winEvent && !idleReq |=> !idleActive && pending);

  a_r8_wake_exit: assert property (@(posedge clk) disable iff (!rstN)
    idleActive && wakeup && !idleReq |=> !idleActive);

  a_r7_exit_cause: assert property (@(posedge clk) disable iff (!rstN)
    $fell(idleActive) |-> ($past(wakeup) || pending));

endmodule

bind idle_tmr idle_tmr_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .pendClr    (pendClr),
  .idleReq    (idleReq),
  .wakeup     (wakeup),
  .irqEnable  (irqEnable),
  .winEvent   (winEvent),
  .pending    (pending),
  .irq        (irq),
  .idleActive (idleActive)
);

// File: tb/idle_tmr_tb.sv
`timescale 1ns/1ps
module idle_tmr_tb;

  localparam int TB = 3;
  localparam int NW = 5;
  localparam int SW = 3;
  localparam int CW = TB + NW - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic selWrEn = 1'b0;
  logic [SW-1:0] selWrData = '0;
  logic irqEnable = 1'b0;
  logic pendClr = 1'b0;
  logic idleReq = 1'b0;
  logic wakeup = 1'b0;
  logic pending, irq, idleActive;

  int checks = 0;
  int errors = 0;
  int cycleCnt = 0;
  int tickDiv = 1;
  logic tickPhase = 1'b0;
  bit finished = 0;

  idle_tmr #(.TAP_BASE(TB), .NUM_WIN(NW), .SEL_W(SW)) u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .selWrEn(selWrEn),
    .selWrData(selWrData), .irqEnable(irqEnable), .pendClr(pendClr),
    .idleReq(idleReq), .wakeup(wakeup), .pending(pending), .irq(irq),
    .idleActive(idleActive)
  );

  always #2.5 clk = ~clk;  // 200 MHz

  // Tick pattern: 0 stopped, 1 every cycle, 2 every other cycle
  always @(negedge clk) begin
    if (tickDiv == 0) tickEn <= 1'b0;
    else if (tickDiv == 1) tickEn <= 1'b1;
    else begin
      tickPhase <= ~tickPhase;
      tickEn <= ~tickPhase;
    end
  end

  // Behavioural reference model
  int mCnt = 0;
  int mSel = 0;
  bit mPrev = 0;
  bit mPend = 0;
  bit mIdle = 0;
  int mEvents = 0;

  always @(posedge clk) begin : model
    int idx;
    bit cur, ev;
    if (!rstN) begin
      mCnt = 0; mSel = 0; mPrev = 0; mPend = 0; mIdle = 0;
    end else begin
      idx = (mSel >= NW - 1) ? NW - 1 : mSel;
      cur = ((mCnt >> (TB - 1 + idx)) & 1) != 0;
      ev = mPrev && !cur;
      if (ev) mEvents++;
      mPend = ev || (mPend && !pendClr);
      if (idleReq) mIdle = 1;
      else if (mIdle && (ev || wakeup)) mIdle = 0;
      mPrev = cur;
      if (selWrEn) mSel = int'(selWrData);
      if (tickEn) mCnt = (mCnt + 1) % (1 << CW);
    end
    cycleCnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (!finished) begin
      check(pending == mPend, "R4 pending vs model", int'(pending), int'(mPend));
      check(irq == (mPend && irqEnable), "R5 irq vs model", int'(irq), int'(mPend && irqEnable));
      check(idleActive == mIdle, "R6 idle vs model", int'(idleActive), int'(mIdle));
    end
  end

  task automatic waitPulse(output int cyc);
    cyc = -1;
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      if (pending) begin
        cyc = cycleCnt;
        return;
      end
    end
  endtask

  task automatic setSel(input int code);
    @(negedge clk); selWrEn <= 1'b1; selWrData <= SW'(code);
    @(negedge clk); selWrEn <= 1'b0;
  endtask

  task automatic measure(input int code, input bit doWrite, input int expGap, input string req);
    int a, b, c;
    if (doWrite) setSel(code);
    waitPulse(a);
    waitPulse(b);
    waitPulse(c);
    check(b >= 0, "R4 event beats held clear", b, 0);
    check(b >= 0 && c - b == expGap, req, c - b, expGap);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    finished = 1;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin : main
    int x, n, seen, evBefore;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pending == 0 && irq == 0 && idleActive == 0, "R1 reset outputs",
          int'({pending, irq, idleActive}), 0);
    rstN <= 1'b1;
    pendClr <= 1'b1;
    tickDiv = 1;

    // R1: default code 0 gives the shortest window
    measure(0, 0, 8, "R1 default window");
    measure(1, 1, 16, "R2 window code 1");
    tickDiv = 2;
    measure(2, 1, 64, "R2 code 2 at half tick rate");
    tickDiv = 1;
    measure(3, 1, 64, "R2 window code 3");
    measure(4, 1, 128, "R2 window code 4");
    measure(5, 1, 128, "R3 code 5 clamps");
    measure(7, 1, 128, "R3 code 7 clamps");

    // R2: stopped ticks produce no events
    repeat (37) @(negedge clk);
    tickDiv = 0;
    repeat (3) @(posedge clk);
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); #1;
      if (pending) seen++;
    end
    check(seen == 0, "R2 no events with tick stopped", seen, 0);

    // R9: select sweep with the counter stopped
    evBefore = mEvents;
    seen = 0;
    for (int r = 0; r < 2; r++) begin
      for (int k = 0; k < NW; k++) begin
        @(negedge clk); selWrEn <= 1'b1; selWrData <= SW'(k);
        @(negedge clk); selWrEn <= 1'b0;
        @(posedge clk); #1; if (pending) seen++;
        @(posedge clk); #1; if (pending) seen++;
      end
    end
    check(seen == mEvents - evBefore, "R9 spurious events on window change", seen, mEvents - evBefore);
    tickDiv = 1;

    // R4 hold, R5 gating, R4 clear
    setSel(4);
    waitPulse(x);
    waitPulse(x);
    @(negedge clk); pendClr <= 1'b0;
    repeat (20) @(negedge clk);
    check(pending == 1, "R4 pending holds without clear", int'(pending), 1);
    check(irq == 0, "R5 irq low when disabled", int'(irq), 0);
    irqEnable <= 1'b1;
    @(negedge clk);
    check(irq == 1, "R5 irq high when enabled", int'(irq), 1);
    pendClr <= 1'b1;
    @(negedge clk); pendClr <= 1'b0;
    check(pending == 0 && irq == 0, "R4 clear strobe", int'({pending, irq}), 0);
    irqEnable <= 1'b0;
    pendClr <= 1'b1;

    // R6 and R7: idle ends on window event
    setSel(0);
    waitPulse(x);
    waitPulse(x);
    @(negedge clk); idleReq <= 1'b1;
    @(negedge clk); idleReq <= 1'b0;
    check(idleActive == 1, "R6 idle entry", int'(idleActive), 1);
    n = 0;
    while (idleActive && n < 100) begin
      @(posedge clk); #1; n++;
    end
    check(!idleActive && pending, "R7 idle exit with pending", int'({idleActive, pending}), 1);
    check(n <= 8, "R7 idle shorter than window", n, 8);

    // R8: wakeup ends idle
    setSel(4);
    waitPulse(x);
    waitPulse(x);
    @(negedge clk); idleReq <= 1'b1;
    @(negedge clk); idleReq <= 1'b0;
    repeat (3) @(negedge clk);
    check(idleActive == 1, "R8 idle held before wakeup", int'(idleActive), 1);
    wakeup <= 1'b1;
    @(negedge clk); wakeup <= 1'b0;
    check(idleActive == 0, "R8 wakeup exit", int'(idleActive), 0);

    // R6: entry wins over simultaneous wakeup
    @(negedge clk); idleReq <= 1'b1; wakeup <= 1'b1;
    @(negedge clk); idleReq <= 1'b0; wakeup <= 1'b0;
    check(idleActive == 1, "R6 entry beats wakeup", int'(idleActive), 1);
    wakeup <= 1'b1;
    @(negedge clk); wakeup <= 1'b0;
    check(idleActive == 0, "R8 second wakeup exit", int'(idleActive), 0);

    repeat (4) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end

endmodule